// File: doc/BRIEF.md
# Pin Interrupt Request Latch

This block lets a small 8-bit CPU use a group of general-purpose port pins as one shared external interrupt source. Each pin is first synchronized to the core clock. A latch records a request when an enabled pin rises. A second option makes the latch also respond to a pin that is simply held high. This lets several open-drain or wired-OR sources share a pin: the request keeps coming back for as long as any of them still drives the pin high.

The latched request is offered to the CPU only while the CPU's global interrupt mask is clear and the block's local enable is set. The CPU takes the request at an instruction boundary. During its vector fetch it pulses an acknowledge strobe, which empties the latch. A new event can therefore be captured while the service routine runs. That event waits until the mask clears on return from interrupt. A separate pending flag shows the raw latch so that software can poll it.

Top module: `ext_irq_latch`

## Requirements
- R1: During reset and in the first cycle after it, `pending_o` and `irq_req_o` are 0.
- R2: While `pin_irq_en` is 0, no pin activity sets the latch, in either mode.
- R3: With `level_mode` = 0, a rising edge on any one of the pins sets `pending_o`. The flag becomes 1 at the third rising clock edge after the pin change: two synchronizer stages, then the latch.
- R4: With `level_mode` = 0, a pin that stays high after its edge does not set the latch again once the latch has been cleared.
- R5: With `level_mode` = 1, a high level on any synchronized pin sets the latch on every cycle it is present, so the request returns after an acknowledge while the pin stays high.
- R6: `irq_req_o` is 1 exactly when `pending_o` is 1, `cpu_mask` is 0 and `irq_enable` is 1.
- R7: A cycle with `vec_fetch` = 1 and no set condition makes `pending_o` 0 from the next cycle on.
- R8: If a set condition and `vec_fetch` occur in the same cycle, the latch is left set.
- R9: A pin that is already high when reset ends is not taken as a rising edge.
- R10: `pending_o` shows the latch whatever the values of `cpu_mask` and `irq_enable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | N_PINS | Asynchronous port pins used as interrupt sources |
| pin_irq_en | input | 1 | Option: pins act as interrupt sources when 1 |
| level_mode | input | 1 | Option: 0 = rising edge only, 1 = edge or high level |
| irq_enable | input | 1 | Local interrupt enable |
| cpu_mask | input | 1 | CPU global interrupt mask; 1 blocks the request |
| vec_fetch | input | 1 | Acknowledge strobe, high during the interrupt vector fetch |
| pending_o | output | 1 | Raw latch state |
| irq_req_o | output | 1 | Gated request to the CPU |

## Verification
A wrong edge history or synchronizer state shows as a pending flag that rises one cycle too early or too late after a pin change. It can also show as a spurious request just after reset when a pin is held high. A latch that misses the set-over-clear priority drops a request, and `pending_o` reads 0 on the cycle after an acknowledge that it should have survived. The reference model compares both outputs on every clock. Any such fault therefore surfaces within one cycle of the step where the correct and faulty behaviour part ways.

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int N_PINS      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              pin_irq_en,
  input  logic              level_mode,
  input  logic              irq_enable,
  input  logic              cpu_mask,
  input  logic              vec_fetch,
  output logic              pending_o,
  output logic              irq_req_o
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [SYNC_STAGES-1:0][N_PINS-1:0] stg_q;
  logic [N_PINS-1:0] prev_q;
  logic [CW-1:0]     warm_q;
  logic              latch_q;

  logic [N_PINS-1:0] sync_w;
  logic armed, rise, high, set_now;

  assign sync_w  = stg_q[SYNC_STAGES-1];
  assign armed   = (warm_q == CW'(WARM));
  assign rise    = armed && |(sync_w & ~prev_q);
  assign high    = level_mode && |sync_w;
  assign set_now = pin_irq_en && (rise || high);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q   <= '0;
      prev_q  <= '0;
      warm_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= sync_w;
      if (!armed) warm_q <= warm_q + 1'b1;
      if (set_now)        latch_q <= 1'b1;
      else if (vec_fetch) latch_q <= 1'b0;
    end
  end

  assign pending_o = latch_q;
  assign irq_req_o = latch_q && !cpu_mask && irq_enable;

  // R2
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_irq_en && !pending_o) |=> !pending_o);
  // R7
  a_r7_fetch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && !set_now) |=> !pending_o);
  // R8
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_now && vec_fetch) |=> pending_o);
  // R6
  a_r6_req_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (pending_o && !cpu_mask));
  // R5
  a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_irq_en && level_mode && sync_w != '0) |=> pending_o);
endmodule

// File: tb/sim_ext_irq_latch.sv
`timescale 1ns/1ps
module sim_ext_irq_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pin_i = '0;
  logic pin_irq_en = 1'b1, level_mode = 1'b0, irq_enable = 1'b0, cpu_mask = 1'b1, vec_fetch = 1'b0;
  logic pending_o, irq_req_o;

  int errors = 0, checks = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_latch u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_irq_en(pin_irq_en),
    .level_mode(level_mode), .irq_enable(irq_enable), .cpu_mask(cpu_mask),
    .vec_fetch(vec_fetch), .pending_o(pending_o), .irq_req_o(irq_req_o));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0] hist[$];
  int  n_edges = 0;
  bit  m_pend = 0;

  always @(posedge clk) begin
    logic [3:0] s, p;
    bit setc;
    if (!rst_n) begin
      hist.delete(); n_edges = 0; m_pend = 0;
    end else begin
      n_edges++;
      hist.push_front(pin_i);
      if (hist.size() > 4) void'(hist.pop_back());
      s = (hist.size() > 2) ? hist[2] : 4'h0;
      p = (hist.size() > 3) ? hist[3] : 4'h0;
      setc = pin_irq_en && ((n_edges >= 4 && (s & ~p) != 0) || (level_mode && s != 0));
      if (setc) m_pend = 1;
      else if (vec_fetch) m_pend = 0;
    end
    #5;
    chk({phase, " pending"}, pending_o, m_pend);
    chk({phase, " irq_req(R6)"}, irq_req_o, m_pend && !cpu_mask && irq_enable);
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 and R9: pin high through reset
    pin_i = 4'b0010;
    step(3);
    chk("R1 pending in reset", pending_o, 1'b0);
    chk("R1 irq in reset", irq_req_o, 1'b0);
    rst_n = 1'b1;
    phase = "R9";
    step(8);
    chk("R9 high pin at reset release", pending_o, 1'b0);

    // R3 rising edge, R10 pending despite mask
    phase = "R3";
    pin_i = 4'b0110;
    step(2);
    chk("R3 not yet after two edges", pending_o, 1'b0);
    step(1);
    chk("R3 set at third edge", pending_o, 1'b1);
    chk("R10 pending while masked", pending_o, 1'b1);
    chk("R6 masked request", irq_req_o, 1'b0);
    phase = "R6";
    cpu_mask = 1'b0; irq_enable = 1'b1;
    step(1);
    chk("R6 request when unmasked", irq_req_o, 1'b1);
    irq_enable = 1'b0;
    step(1);
    chk("R6 local enable off", irq_req_o, 1'b0);
    chk("R10 pending with enable off", pending_o, 1'b1);

    // R7 clear and R4 held pin does not re-set
    phase = "R7";
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R7 cleared by fetch", pending_o, 1'b0);
    phase = "R4";
    step(5);
    chk("R4 held high no re-set", pending_o, 1'b0);

    // R2 disabled
    phase = "R2";
    pin_irq_en = 1'b0;
    pin_i = 4'b0000; step(3);
    pin_i = 4'b1111; step(5);
    level_mode = 1'b1; step(4);
    chk("R2 no set when disabled", pending_o, 1'b0);

    // R5 level mode with acknowledge while high
    phase = "R5";
    pin_irq_en = 1'b1;
    step(1);
    chk("R5 level sets", pending_o, 1'b1);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R5 request returns while high", pending_o, 1'b1);
    pin_i = 4'b0000; step(3);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R5 clears once low", pending_o, 1'b0);

    // R8 edge meets fetch
    phase = "R8";
    level_mode = 1'b0;
    pin_i = 4'b0001; step(3);
    pin_i = 4'b0000; step(3);
    pin_i = 4'b1000; step(2);
    vec_fetch = 1'b1; step(1); vec_fetch = 1'b0;
    chk("R8 set wins over clear", pending_o, 1'b1);

    // mixed stimulus, model compared every clock
    phase = "R3/R5/R6/R7 random";
    for (int i = 0; i < 400; i++) begin
      pin_i      = 4'($urandom);
      pin_irq_en = ($urandom % 8) != 0;
      level_mode = ($urandom % 4) == 0;
      irq_enable = $urandom % 2;
      cpu_mask   = $urandom % 2;
      vec_fetch  = ($urandom % 3) == 0;
      step(1);
    end
    phase = "R1 second reset";
    rst_n = 1'b0; pin_i = 4'hF; step(2);
    rst_n = 1'b1; vec_fetch = 1'b0; level_mode = 1'b0; step(1);
    chk("R1 after reset", pending_o, 1'b0);
    phase = "R9 second";
    step(6);
    chk("R9 no edge from held pins", pending_o, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule